// File: doc/BRIEF.md
# I/O Page-Directory Address Translator

This block turns an address arriving from an I/O bus into a system physical page address. It accepts one request at a time on a valid/ready port. The block clears the request's page offset and then decides between two paths. The first is a fixed default mapping. The second is a walk through a page directory that sits in system memory. That walk makes one 64-bit read through a dedicated memory read port.

Three configuration registers steer the decision, each written through its own write-enable port: a window base with an enable flag in bit 0, a window mask, and the directory's base address. When the window is enabled and the masked page address equals the base, the block fetches an 8-byte directory entry and checks its top-bit valid flag. Otherwise it returns the default mapping. That mapping passes high addresses through unchanged and takes the result of an external 32-to-40-bit function for addresses that fit in 32 bits. The response carries the page address, an offset mask and an ok/fault flag. It stays on the port until the consumer takes it.

Top module: `iopt_xlate`

## Requirements
- R1: In reset and right after it, `req_ready` is 1, while `rsp_valid` and `mem_rd_en` are 0.
- R2: The low 12 bits of every request address are treated as zero. Every response reports `rsp_mask` = 0xFFF, and a returned page always has its low 12 bits at zero.
- R3: When bit 0 of the window base register is 0, no memory read occurs. The response carries the default mapping with `rsp_ok` = 1, two cycles after acceptance.
- R4: When the window is enabled but (page address AND mask) differs from the base with bit 0 cleared, no memory read occurs. The response carries the default mapping with `rsp_ok` = 1.
- R5: On a window hit, `mem_rd_en` rises one cycle after the check. `mem_rd_addr` = directory base + (page address >> 12) * 8, and both hold until `mem_rd_valid` is seen.
- R6: If bit 63 of the fetched word is 1, the response gives that word with bit 63 and bits 11:0 cleared, and `rsp_ok` = 1.
- R7: If bit 63 of the fetched word is 0, the response gives `rsp_ok` = 0 and `rsp_page` = 0.
- R8: The default mapping is the page address itself when bits 63:32 of that address are nonzero. Otherwise it is `req_dflt_map` sampled at acceptance, with its low 12 bits cleared.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, the response fields do not change. `req_ready` stays 0 from acceptance until the response handshake completes, and a request offered in that time is ignored.
- R10: A configuration write made while a request is in flight does not change that request's result. It applies from the next accepted request onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | 64 | I/O-side address |
| req_dflt_map | input | 64 | External fixed mapping of `req_addr` for 32-bit addresses |
| cfg_base_we | input | 1 | Write strobe for the window base |
| cfg_base_wdata | input | 64 | Window base, bit 0 enables the window |
| cfg_mask_we | input | 1 | Write strobe for the window mask |
| cfg_mask_wdata | input | 64 | Window mask |
| cfg_dir_we | input | 1 | Write strobe for the directory base |
| cfg_dir_wdata | input | 64 | Directory base address |
| mem_rd_en | output | 1 | Directory read request, held until data returns |
| mem_rd_addr | output | 64 | Byte address of the directory entry |
| mem_rd_valid | input | 1 | Read data present |
| mem_rd_data | input | 64 | Directory entry, little-endian word |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_page | output | 64 | Translated page address |
| rsp_mask | output | 64 | Page offset mask |
| rsp_ok | output | 1 | 1 = read/write permitted, 0 = fault |

## Verification
The assertions assume that the memory side raises `mem_rd_valid` only while `mem_rd_en` is high. They also assume that `req_dflt_map` is valid for the address offered in the same cycle. The bench keeps to both. Its memory responder is driven from the reference model's own fetch phase and counts a chosen latency there. Every request drives the default-map input from a bench function of the very address it offers, including the requests it offers while a response is still pending.

// File: rtl/iopt_pkg.sv
// Shared types for the I/O page-directory translator.
// Assumes: a single request in flight, so four phases are enough.
package iopt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_FETCH = 2'd2,
        ST_RESP  = 2'd3
    } iopt_state_e;

endpackage

// File: rtl/iopt_cfg_regs.sv
// Configuration store: window base (bit 0 = enable), window mask and
// directory base. Each register has its own write strobe.
// Assumes: there is no read-back; the values reset to zero (window disabled).
module iopt_cfg_regs #(
    parameter int AW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_we,
    input  logic [AW-1:0] base_wdata,
    input  logic          mask_we,
    input  logic [AW-1:0] mask_wdata,
    input  logic          dir_we,
    input  logic [AW-1:0] dir_wdata,
    output logic [AW-1:0] base_q,
    output logic [AW-1:0] mask_q,
    output logic [AW-1:0] dir_q
);

    // Register each field on its own strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
            dir_q  <= '0;
        end else begin
            if (base_we) base_q <= base_wdata;
            if (mask_we) mask_q <= mask_wdata;
            if (dir_we)  dir_q  <= dir_wdata;
        end
    end

endmodule

// File: rtl/iopt_range_match.sv
// Window decision: a hit needs the enable flag and a masked compare
// against the base with its flag bit cleared.
// Assumes: the address given is already page aligned.
module iopt_range_match #(
    parameter int AW = 64
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] mask,
    output logic          hit
);

    logic [AW-1:0] base_cmp;

    // Form the comparison value and the hit flag.
    always_comb begin
        base_cmp = {base[AW-1:1], 1'b0};
        hit      = base[0] && ((addr & mask) == base_cmp);
    end

endmodule

// File: rtl/iopt_entry_decode.sv
// Directory entry decode: the top bit is the valid flag. The page is the
// word with that flag and the offset bits removed.
// Assumes: the entry arrives already assembled as a little-endian word.
module iopt_entry_decode #(
    parameter int AW         = 64,
    parameter int PAGE_SHIFT = 12
) (
    input  logic [AW-1:0] entry,
    output logic          valid,
    output logic [AW-1:0] page
);

    localparam logic [AW-1:0] OFF_MASK  = {{(AW-PAGE_SHIFT){1'b0}}, {PAGE_SHIFT{1'b1}}};
    localparam logic [AW-1:0] FLAG_MASK = {1'b1, {(AW-1){1'b0}}};

    // Split the entry into its flag and its page address.
    always_comb begin
        valid = entry[AW-1];
        page  = entry & ~(FLAG_MASK | OFF_MASK);
    end

endmodule

// File: rtl/iopt_xlate.sv
// I/O page-directory translator top. It accepts one address and picks
// either the default mapping or a directory walk, then holds the result
// until it is taken.
// Assumes: mem_rd_valid comes only while mem_rd_en is high, and
// req_dflt_map matches req_addr in the cycle of acceptance.
module iopt_xlate #(
    parameter int AW         = 64,
    parameter int PAGE_SHIFT = 12,
    parameter int LOW_W      = 32,
    parameter int ENTRY_LOG2 = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [AW-1:0] req_dflt_map,
    input  logic          cfg_base_we,
    input  logic [AW-1:0] cfg_base_wdata,
    input  logic          cfg_mask_we,
    input  logic [AW-1:0] cfg_mask_wdata,
    input  logic          cfg_dir_we,
    input  logic [AW-1:0] cfg_dir_wdata,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rd_valid,
    input  logic [AW-1:0] mem_rd_data,
    output logic          rsp_valid,
    input  logic          rsp_ready,
    output logic [AW-1:0] rsp_page,
    output logic [AW-1:0] rsp_mask,
    output logic          rsp_ok
);
    import iopt_pkg::*;

    localparam logic [AW-1:0] OFF_MASK = {{(AW-PAGE_SHIFT){1'b0}}, {PAGE_SHIFT{1'b1}}};

    iopt_state_e   state_q;
    logic [AW-1:0] cfg_base, cfg_mask, cfg_dir;
    logic [AW-1:0] addr_q, dflt_q, sbase_q, smask_q, sdir_q, page_q;
    logic          ok_q;
    logic [AW-1:0] addr_al, dflt_now;
    logic          accept, hit, ent_valid;
    logic [AW-1:0] ent_page;

    iopt_cfg_regs #(.AW(AW)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .base_we(cfg_base_we), .base_wdata(cfg_base_wdata),
        .mask_we(cfg_mask_we), .mask_wdata(cfg_mask_wdata),
        .dir_we(cfg_dir_we),   .dir_wdata(cfg_dir_wdata),
        .base_q(cfg_base), .mask_q(cfg_mask), .dir_q(cfg_dir)
    );

    iopt_range_match #(.AW(AW)) u_match (
        .addr(addr_q), .base(sbase_q), .mask(smask_q), .hit(hit)
    );

    iopt_entry_decode #(.AW(AW), .PAGE_SHIFT(PAGE_SHIFT)) u_dec (
        .entry(mem_rd_data), .valid(ent_valid), .page(ent_page)
    );

    // Align the request and choose its default mapping at the port.
    always_comb begin
        addr_al  = req_addr & ~OFF_MASK;
        dflt_now = (addr_al[AW-1:LOW_W] == '0) ? (req_dflt_map & ~OFF_MASK) : addr_al;
        accept   = req_valid && (state_q == ST_IDLE);
    end

    // Sequence one request through check, optional fetch and response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            dflt_q  <= '0;
            sbase_q <= '0;
            smask_q <= '0;
            sdir_q  <= '0;
            page_q  <= '0;
            ok_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    addr_q  <= addr_al;
                    dflt_q  <= dflt_now;
                    sbase_q <= cfg_base;
                    smask_q <= cfg_mask;
                    sdir_q  <= cfg_dir;
                    state_q <= ST_CHECK;
                end
                ST_CHECK: if (hit) begin
                    state_q <= ST_FETCH;
                end else begin
                    page_q  <= dflt_q;
                    ok_q    <= 1'b1;
                    state_q <= ST_RESP;
                end
                ST_FETCH: if (mem_rd_valid) begin
                    page_q  <= ent_valid ? ent_page : '0;
                    ok_q    <= ent_valid;
                    state_q <= ST_RESP;
                end
                ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the port outputs from the phase and the held results.
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        mem_rd_en   = (state_q == ST_FETCH);
        mem_rd_addr = sdir_q + ((addr_q >> PAGE_SHIFT) << ENTRY_LOG2);
        rsp_valid   = (state_q == ST_RESP);
        rsp_page    = page_q;
        rsp_mask    = OFF_MASK;
        rsp_ok      = ok_q;
    end

    p_rsp_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_page) && $stable(rsp_ok));

    p_no_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    p_page_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_page & OFF_MASK) == '0);

    p_fault_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ok |-> rsp_page == '0);

    p_rd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en && !mem_rd_valid |=> mem_rd_en && $stable(mem_rd_addr));

    p_cfg_isolated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en && !mem_rd_valid |=> $stable(sbase_q) && $stable(sdir_q));

endmodule

// File: tb/iopt_xlate_test.sv
`timescale 1ns/1ps
module iopt_xlate_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_addr = '0, req_dflt_map = '0;
    logic        cfg_base_we = 1'b0, cfg_mask_we = 1'b0, cfg_dir_we = 1'b0;
    logic [63:0] cfg_base_wdata = '0, cfg_mask_wdata = '0, cfg_dir_wdata = '0;
    logic        mem_rd_en;
    logic [63:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [63:0] mem_rd_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [63:0] rsp_page, rsp_mask;
    logic        rsp_ok;

    int checks = 0;
    int errors = 0;
    string tag = "R1";
    int cur_lat = 0;
    logic [63:0] dmem [logic [63:0]];

    // reference model state
    int m_st = 0;
    int m_wait = 0;
    logic [63:0] m_base = '0, m_mask = '0, m_dir = '0;
    logic [63:0] s_base = '0, s_mask = '0, s_dir = '0;
    logic [63:0] m_addr = '0, m_dflt = '0, m_page = '0;
    bit m_ok = 0;

    iopt_xlate uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_dflt_map(req_dflt_map),
        .cfg_base_we(cfg_base_we), .cfg_base_wdata(cfg_base_wdata),
        .cfg_mask_we(cfg_mask_we), .cfg_mask_wdata(cfg_mask_wdata),
        .cfg_dir_we(cfg_dir_we), .cfg_dir_wdata(cfg_dir_wdata),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_page(rsp_page), .rsp_mask(rsp_mask), .rsp_ok(rsp_ok)
    );

    always #5 clk = ~clk;

    // Bench's own fixed 32-to-40-bit mapping.
    function automatic logic [63:0] dfn(input logic [63:0] a);
        if (a[31:28] == 4'hF) return 64'h0000_00F0_0000_0000 | {32'h0, a[31:0]};
        return {32'h0, a[31:0]};
    endfunction

    function automatic logic [63:0] rd_word(input logic [63:0] a);
        if (dmem.exists(a)) return dmem[a];
        return 64'h0;
    endfunction

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference model: advances on every edge from the bench-driven inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_base = 0; m_mask = 0; m_dir = 0; m_ok = 0; m_page = 0;
        end else begin
            case (m_st)
                0: if (req_valid) begin
                    s_base = m_base; s_mask = m_mask; s_dir = m_dir;
                    m_addr = {req_addr[63:12], 12'h0};
                    m_dflt = (m_addr < 64'h1_0000_0000) ? {req_dflt_map[63:12], 12'h0} : m_addr;
                    m_st = 1;
                end
                1: if (s_base[0] == 1'b1 && (m_addr & s_mask) == {s_base[63:1], 1'b0}) begin
                    m_st = 2; m_wait = 0;
                end else begin
                    m_page = m_dflt; m_ok = 1; m_st = 3;
                end
                2: if (mem_rd_valid) begin
                    if (mem_rd_data[63]) begin
                        m_page = {1'b0, mem_rd_data[62:12], 12'h0}; m_ok = 1;
                    end else begin
                        m_page = 0; m_ok = 0;
                    end
                    m_st = 3;
                end else m_wait++;
                default: if (rsp_ready) m_st = 0;
            endcase
            if (cfg_base_we) m_base = cfg_base_wdata;
            if (cfg_mask_we) m_mask = cfg_mask_wdata;
            if (cfg_dir_we)  m_dir  = cfg_dir_wdata;
        end
    end

    // Memory responder, paced by the model's fetch phase.
    always @(negedge clk) begin
        mem_rd_valid <= (m_st == 2) && (m_wait >= cur_lat);
        mem_rd_data  <= (m_st == 2) ? rd_word(s_dir + ((m_addr >> 12) << 3)) : 64'h0;
    end

    // Compare all outputs with the model on every cycle out of reset.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R9 req_ready", {63'h0, req_ready}, {63'h0, m_st == 0});
            chk("R9 rsp_valid", {63'h0, rsp_valid}, {63'h0, m_st == 3});
            chk("R5 mem_rd_en", {63'h0, mem_rd_en}, {63'h0, m_st == 2});
            if (m_st == 2) chk("R5 mem_rd_addr", mem_rd_addr, s_dir + ((m_addr >> 12) << 3));
            if (m_st == 3) begin
                chk("R6 rsp_page", rsp_page, m_page);
                chk("R7 rsp_ok", {63'h0, rsp_ok}, {63'h0, m_ok});
                chk("R2 rsp_mask", rsp_mask, 64'hFFF);
            end
        end
    end

    task automatic cfg_write(input int which, input logic [63:0] v);
        @(negedge clk);
        case (which)
            0: begin cfg_base_we = 1; cfg_base_wdata = v; end
            1: begin cfg_mask_we = 1; cfg_mask_wdata = v; end
            default: begin cfg_dir_we = 1; cfg_dir_wdata = v; end
        endcase
        @(negedge clk);
        cfg_base_we = 0; cfg_mask_we = 0; cfg_dir_we = 0;
    endtask

    task automatic txn(input logic [63:0] a, input int lat, input int hold,
                       input bit pester, input bit midw, input logic [63:0] midv);
        bit pend;
        pend = midw;
        @(negedge clk);
        cur_lat = lat;
        req_valid = 1; req_addr = a; req_dflt_map = dfn(a);
        @(negedge clk);
        req_valid = 0;
        while (m_st != 3) begin
            if (pend && m_st == 2) begin
                cfg_base_we = 1; cfg_base_wdata = midv; pend = 0;
                @(negedge clk);
                cfg_base_we = 0;
            end else @(negedge clk);
        end
        for (int i = 0; i < hold; i++) begin
            if (pester) begin
                req_valid = 1; req_addr = a ^ 64'h5000; req_dflt_map = dfn(a ^ 64'h5000);
            end
            @(negedge clk);
        end
        req_valid = 0; rsp_ready = 1;
        @(negedge clk);
        rsp_ready = 0;
    endtask

    task automatic expect_rsp(input string what, input logic [63:0] page, input bit ok);
        chk({what, " model page"}, m_page, page);
        chk({what, " model ok"}, {63'h0, m_ok}, {63'h0, ok});
    endtask

    initial begin
        dmem[64'h50_0028] = 64'h8000_00AB_CDEF_0FFF;
        dmem[64'h50_0090] = 64'h8000_0000_1234_5000;
        dmem[64'h50_0098] = 64'h0000_0012_3456_7000;

        repeat (3) @(negedge clk);
        tag = "R1";
        chk("R1 req_ready", {63'h0, req_ready}, 64'h1);
        chk("R1 rsp_valid", {63'h0, rsp_valid}, 64'h0);
        chk("R1 mem_rd_en", {63'h0, mem_rd_en}, 64'h0);
        rst_n = 1;

        tag = "R3";   // window disabled after reset
        txn(64'h12_3456_7ABC, 0, 0, 0, 0, 0);
        expect_rsp("R3 high passthrough", 64'h12_3456_7000, 1);
        tag = "R8";   // 32-bit range uses the external mapping
        txn(64'hF123_4567, 0, 0, 0, 0, 0);
        expect_rsp("R8 low mapped", 64'hF0_F123_4000, 1);
        txn(64'hFFFF_FFFF, 0, 0, 0, 0, 0);
        expect_rsp("R8 top of 32-bit", 64'hF0_FFFF_F000, 1);
        txn(64'h1_0000_0FFF, 0, 0, 0, 0, 0);
        expect_rsp("R8 first high page", 64'h1_0000_0000, 1);

        cfg_write(1, 64'hFFFF_FFFF_F000_0000);
        cfg_write(2, 64'h0010_0000);
        cfg_write(0, 64'h8000_0001);

        tag = "R4";   // enabled, outside window
        txn(64'h4000_1234, 0, 0, 0, 0, 0);
        expect_rsp("R4 miss", 64'h4000_1000, 1);

        tag = "R6";   // hit, valid entry, immediate data
        txn(64'h8000_5678, 0, 0, 0, 0, 0);
        expect_rsp("R6 valid", 64'h0000_00AB_CDEF_0000, 1);
        tag = "R5";   // hit with slow memory
        txn(64'h8001_2FFF, 3, 0, 0, 0, 0);
        expect_rsp("R5 slow", 64'h1234_5000, 1);

        tag = "R7";   // invalid entries
        txn(64'h8001_3000, 1, 0, 0, 0, 0);
        expect_rsp("R7 flag clear", 64'h0, 0);
        txn(64'h8002_0000, 0, 0, 0, 0, 0);
        expect_rsp("R7 empty", 64'h0, 0);

        tag = "R9";   // consumer stalls while another request is offered
        txn(64'h8000_5000, 2, 4, 1, 0, 0);
        expect_rsp("R9 held", 64'h0000_00AB_CDEF_0000, 1);
        txn(64'hF000_0000, 0, 3, 1, 0, 0);
        expect_rsp("R9 held bypass", 64'hF0_F000_0000, 1);

        tag = "R10";  // disable the window in mid-walk
        txn(64'h8000_5001, 5, 0, 0, 1, 64'h8000_0000);
        expect_rsp("R10 current walk", 64'h0000_00AB_CDEF_0000, 1);
        txn(64'h8000_5001, 0, 0, 0, 0, 0);
        expect_rsp("R10 next request", 64'h8000_5000, 1);
        tag = "R2";
        txn(64'hABC, 0, 1, 0, 0, 0);
        expect_rsp("R2 offset cleared", 64'h0, 1);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule